// File: doc/BRIEF.md
# Three-Tier Stacked SRAM with Per-Tier Row Decoding

This block models a small static memory whose rows are spread over three stacked tiers. Every tier carries sixteen rows of one 8-bit word, so the array holds 48 words. One pair of bit lines runs through all three tiers, which means the whole array behaves as a single 48-row column when it is read. The word count is therefore a multiple of three and not a power of two.

Each tier has its own copy of the 4-to-16 row decoder. All copies see the same low four address bits. A small per-tier decode of the two upper address bits enables one copy and holds the other two quiet. The decoders share the precharge phase signal: wordlines may rise only while the phase input says evaluate. Writes and reads take effect on the rising clock edge of an evaluate cycle. Reads are registered through a single mux over all 48 rows, and the mux is steered by the one-hot wordline vector. An access whose tier code selects no tier touches nothing, returns zero and raises a one-cycle error flag.

Top module: `stk_sram_top`

## Requirements
- R1: After reset, rd_data and addr_err are 0 and every one of the 48 words reads back as 0x00.
- R2: While eval_ph is 1 and addr[5:4] is 00, 01 or 10, exactly wordline bit addr is 1. Bits 0-15 belong to the top tier (code 00), bits 16-31 to the middle tier (code 01) and bits 32-47 to the bottom tier (code 10). Within a tier the bit index is addr[3:0].
- R3: At no time is more than one of the 48 wordline bits high.
- R4: While eval_ph is 0 (precharge), all wordlines are 0. A write request in that cycle changes no word, and rd_data holds its value.
- R5: A rising edge with eval_ph=1, wr_en=1 and a valid address stores wr_data in the addressed word. rd_data holds its value across that edge.
- R6: A rising edge with eval_ph=1, wr_en=0 and a valid address loads rd_data with the stored word, visible right after that edge.
- R7: With addr[5:4]=11, no wordline rises, a write is ignored in every tier, and a read loads rd_data with 0x00.
- R8: addr_err is 1 for exactly the cycle after a rising edge at which eval_ph=1 and addr[5:4]=11. Otherwise it is 0.
- R9: A write to row r of one tier leaves row r of the other two tiers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eval_ph | input | 1 | Phase: 1 evaluate, 0 bit-line precharge |
| addr | input | 6 | [5:4] tier code, [3:0] row within tier |
| wr_en | input | 1 | 1 write, 0 read |
| wr_data | input | 8 | Write data |
| wordline | output | 48 | One-hot wordlines, tier-major |
| rd_data | output | 8 | Registered read data |
| addr_err | output | 1 | One-cycle flag for an access with no tier selected |

## Verification
The wordlines depend on the inputs through logic alone, with no register in the path. The bench therefore checks them 1 ns after it drives the inputs on the falling edge, before the next rising edge. rd_data and addr_err each pass through one register and are due right after the rising edge that samples the access. The bench checks them 1 ns after that edge, against a model memory held in the bench. A write or a precharge cycle is followed in the same way by a check that rd_data kept its value. Aliasing between tiers is checked by reading back all three tiers of one row after each of them is written.

// File: rtl/stk_pkg.sv
// Shared sizing for the three-tier stacked memory.
// Assumes tiers are numbered from the top (0) downwards.
package stk_pkg;
    localparam int TIERS  = 3;   // stacked tiers
    localparam int ROW_AW = 4;   // row address bits per tier
    localparam int WORD_W = 8;   // bits per word
endpackage

// File: rtl/stk_tier_select.sv
// Per-tier select decode: enables one tier's row decoder when the tier
// code matches this tier and the phase is evaluate.
// Assumes TIER_ID fits in TSEL_W bits.
module stk_tier_select #(
    parameter int TSEL_W  = 2,
    parameter int TIER_ID = 0
) (
    input  logic              eval_ph,
    input  logic [TSEL_W-1:0] tsel,
    output logic              tier_en
);
    // Compare the tier code against this tier's fixed identity.
    always_comb tier_en = eval_ph && (tsel == TSEL_W'(TIER_ID));
endmodule

// File: rtl/stk_row_decoder.sv
// Gated 4-to-16 style row decoder, one copy per tier.
// Assumes the enable already carries the evaluate phase.
module stk_row_decoder #(
    parameter int ROW_AW = 4,
    localparam int ROWS  = 1 << ROW_AW
) (
    input  logic              en,
    input  logic [ROW_AW-1:0] row,
    output logic [ROWS-1:0]   wl
);
    // One comparator per row output.
    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign wl[i] = en && (row == ROW_AW'(i));
    end
endmodule

// File: rtl/stk_word_store.sv
// Word storage for all tiers plus the shared read path.
// Assumes the wordline vector is one-hot or zero. The read mux ORs the
// words gated by the wordlines, so an empty wordline vector reads zero.
module stk_word_store #(
    parameter int WORDS  = 48,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORDS-1:0]  wordline,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [WORDS];
    logic [WORD_W-1:0] bitline;

    // One storage word per row; writes follow the active wordline.
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                    mem[i] <= '0;
            else if (wr_en && wordline[i]) mem[i] <= wr_data;
        end
    end

    // Shared bit-line model: a single AND-OR mux over every row.
    always_comb begin
        bitline = '0;
        for (int i = 0; i < WORDS; i++)
            bitline |= mem[i] & {WORD_W{wordline[i]}};
    end

    // Sense capture: load read data on an evaluate read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= bitline;
    end
endmodule

// File: rtl/stk_sram_top.sv
// Three-tier stacked memory with a row decoder cloned on each tier.
// The upper address bits pick a tier, the lower bits a row. Tier codes at
// or above TIERS select nothing and raise a one-cycle error flag.
// Assumes eval_ph is stable around the rising clock edge.
module stk_sram_top #(
    parameter int TIERS  = stk_pkg::TIERS,
    parameter int ROW_AW = stk_pkg::ROW_AW,
    parameter int WORD_W = stk_pkg::WORD_W,
    localparam int ROWS   = 1 << ROW_AW,
    localparam int WORDS  = TIERS * ROWS,
    localparam int TSEL_W = $clog2(TIERS),
    localparam int AW     = TSEL_W + ROW_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_ph,
    input  logic [AW-1:0]     addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORDS-1:0]  wordline,
    output logic [WORD_W-1:0] rd_data,
    output logic              addr_err
);
    logic [TSEL_W-1:0] tsel;
    logic [ROW_AW-1:0] row;
    logic [TIERS-1:0]  tier_en;
    logic              bad_access;

    assign tsel = addr[AW-1:ROW_AW];
    assign row  = addr[ROW_AW-1:0];

    // One tier-select decode and one row-decoder clone per tier.
    for (genvar t = 0; t < TIERS; t++) begin : g_tier
        stk_tier_select #(.TSEL_W(TSEL_W), .TIER_ID(t)) u_tsel (
            .eval_ph (eval_ph),
            .tsel    (tsel),
            .tier_en (tier_en[t])
        );
        stk_row_decoder #(.ROW_AW(ROW_AW)) u_rdec (
            .en  (tier_en[t]),
            .row (row),
            .wl  (wordline[t*ROWS +: ROWS])
        );
    end

    stk_word_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wordline (wordline),
        .wr_en    (wr_en),
        .rd_en    (eval_ph && !wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data)
    );

    // Out-of-range detect: an evaluate access whose tier code maps to no tier.
    always_comb bad_access = eval_ph && (32'(tsel) >= TIERS);

    // Error flag: high for the one cycle after a bad access.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_err <= 1'b0;
        else        addr_err <= bad_access;
    end
endmodule

// File: rtl/stk_sram_checker.sv
// Protocol checker for stk_sram_top, attached through bind.
// Assumes the default three-tier geometry for the tier-code constant 3.
module stk_sram_checker #(
    parameter int WORDS  = 48,
    parameter int AW     = 6,
    parameter int ROW_AW = 4,
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eval_ph,
    input logic [AW-1:0]     addr,
    input logic              wr_en,
    input logic [WORDS-1:0]  wordline,
    input logic [WORD_W-1:0] rd_data,
    input logic              addr_err
);
    logic no_tier;
    assign no_tier = (32'(addr[AW-1:ROW_AW]) * (1 << ROW_AW)) >= WORDS;

    assert_addr_maps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_ph && !no_tier) |-> (wordline == (WORDS'(1) << addr)));

    assert_single_wl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wordline));

    assert_precharge_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_ph |-> (wordline == '0));

    assert_precharge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_ph |=> $stable(rd_data));

    assert_write_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_ph && wr_en) |=> $stable(rd_data));

    assert_no_tier_wl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_ph && no_tier) |-> (wordline == '0));

    assert_no_tier_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_ph && no_tier && !wr_en) |=> (rd_data == '0));

    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_ph && no_tier) |=> addr_err);

    assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(eval_ph && no_tier) |=> !addr_err);
endmodule

bind stk_sram_top stk_sram_checker #(
    .WORDS(WORDS), .AW(AW), .ROW_AW(ROW_AW), .WORD_W(WORD_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .eval_ph(eval_ph), .addr(addr), .wr_en(wr_en),
    .wordline(wordline), .rd_data(rd_data), .addr_err(addr_err)
);

// File: tb/stk_sram_top_bench.sv
// Self-checking bench: directed corners plus seeded random traffic.
module stk_sram_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval_ph = 1'b0;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [47:0] wordline;
    logic [7:0]  rd_data;
    logic        addr_err;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    logic [7:0] model [48];
    logic [7:0] last_rd = '0;

    always #5 clk = ~clk;

    stk_sram_top u_stk_sram_top (
        .clk(clk), .rst_n(rst_n), .eval_ph(eval_ph), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .wordline(wordline),
        .rd_data(rd_data), .addr_err(addr_err)
    );

    function automatic logic [47:0] exp_wl(input logic e, input logic [5:0] a);
        if (e && a < 6'd48) return 48'd1 << a;
        return '0;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, check wordlines, then outputs.
    task automatic cycle(input logic e, input logic w, input logic [5:0] a,
                         input logic [7:0] d, input string req);
        logic [47:0] ewl;
        logic [7:0]  erd;
        bit bad;
        @(negedge clk);
        eval_ph = e; wr_en = w; addr = a; wr_data = d;
        #1;
        ewl = exp_wl(e, a);
        check(wordline == ewl, {req, " R2 R3 R4 R7 wordline"}, 64'(wordline), 64'(ewl));
        bad = e && (a[5:4] == 2'b11);
        erd = last_rd;
        if (e && !w) erd = (a < 6'd48) ? model[a] : 8'h00;
        if (e && w && a < 6'd48) model[a] = d;
        @(posedge clk);
        #1;
        check(rd_data == erd, {req, " R5 R6 R7 rd_data"}, 64'(rd_data), 64'(erd));
        check(addr_err == bad, {req, " R8 addr_err"}, 64'(addr_err), 64'(bad));
        last_rd = erd;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 48; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rd_data == 8'h00, "R1 rd_data after reset", 64'(rd_data), 64'h0);
        check(addr_err == 1'b0, "R1 addr_err after reset", 64'(addr_err), 64'h0);
        check(wordline == '0, "R1 R4 wordline in precharge", 64'(wordline), 64'h0);

        // R1: all words clear after reset
        for (int a = 0; a < 48; a++) cycle(1'b1, 1'b0, 6'(a), 8'h00, "R1 reset read");

        // R9 / R5 / R6: same row in each tier, written in turn, no aliasing
        cycle(1'b1, 1'b1, 6'd5,  8'hA5, "R9 write top");
        cycle(1'b1, 1'b0, 6'd21, 8'h00, "R9 middle untouched");
        cycle(1'b1, 1'b0, 6'd37, 8'h00, "R9 bottom untouched");
        cycle(1'b1, 1'b1, 6'd21, 8'h5A, "R9 write middle");
        cycle(1'b1, 1'b1, 6'd37, 8'h3C, "R9 write bottom");
        cycle(1'b1, 1'b0, 6'd5,  8'h00, "R9 top kept");
        cycle(1'b1, 1'b0, 6'd21, 8'h00, "R9 middle kept");
        cycle(1'b1, 1'b0, 6'd37, 8'h00, "R9 bottom kept");

        // Tier edge rows
        cycle(1'b1, 1'b1, 6'd15, 8'hFF, "R5 top last row");
        cycle(1'b1, 1'b1, 6'd16, 8'h01, "R5 middle first row");
        cycle(1'b1, 1'b1, 6'd47, 8'h80, "R5 bottom last row");
        cycle(1'b1, 1'b0, 6'd15, 8'h00, "R6 top last row");
        cycle(1'b1, 1'b0, 6'd47, 8'h00, "R6 bottom last row");

        // R4: a precharge write changes nothing, rd_data holds
        cycle(1'b0, 1'b1, 6'd15, 8'h11, "R4 precharge write");
        cycle(1'b0, 1'b0, 6'd47, 8'h00, "R4 precharge read");
        cycle(1'b1, 1'b0, 6'd15, 8'h00, "R4 word kept");

        // R7 / R8: no tier selected; writes ignored, reads zero, flag one cycle
        cycle(1'b1, 1'b1, 6'd53, 8'hEE, "R7 write no tier");
        cycle(1'b1, 1'b0, 6'd48, 8'h00, "R7 read no tier");
        cycle(1'b1, 1'b0, 6'd5,  8'h00, "R7 R8 flag clears");
        cycle(1'b1, 1'b0, 6'd53, 8'h00, "R7 read no tier again");
        for (int r = 0; r < 16; r++) begin
            cycle(1'b1, 1'b1, 6'(48 + r), 8'hC3, "R7 sweep write");
            cycle(1'b1, 1'b0, 6'(r),      8'h00, "R7 top row intact");
            cycle(1'b1, 1'b0, 6'(16 + r), 8'h00, "R7 middle row intact");
            cycle(1'b1, 1'b0, 6'(32 + r), 8'h00, "R7 bottom row intact");
        end
        cycle(1'b0, 1'b0, 6'd60, 8'h00, "R8 precharge no flag");

        // Constrained random traffic: A5/5A patterns mixed with others
        for (int n = 0; n < 600; n++) begin
            logic [5:0] a;
            logic [7:0] d;
            logic e, w;
            a = 6'($urandom % 64);
            e = ($urandom % 8) != 0;
            w = ($urandom % 2) != 0;
            case ($urandom % 3)
                0: d = 8'hA5;
                1: d = 8'h5A;
                default: d = 8'($urandom);
            endcase
            cycle(e, w, a, d, "R2 R9 random");
        end

        // Final sweep of all words against the model
        for (int a = 0; a < 48; a++) cycle(1'b1, 1'b0, 6'(a), 8'h00, "R6 R9 final sweep");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule